// File: doc/BRIEF.md
# Fractional Predivider Clock Generator

This block derives one output clock from a choice of three sources: a crystal reference and two PLL outputs. The chosen source runs through a predivider that divides by 2, 2.5 or 3. A second stage then divides by an integer from 2 to 127. Each source arrives as a strobe on `src_edge`. The strobe is high for one system-clock cycle per source edge, rising or falling, so it marks one half-period of that source. The block counts half-periods, which is how it reaches the 2.5 ratio: one predivider step is five half-periods. `clk_out` is always a flop output in the system-clock domain, so it cannot glitch.

One 16-bit configuration word controls the block. It holds a two-flag source select, a predivider code, the divisor and an enable bit. A new word is taken into the active setting only when an output period ends, or at any time while the block is disabled. A word with an illegal divisor or predivider code is never applied.

Top module: `clk_frac_gen`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low. On leaving reset the active setting is the crystal source, predivider code 1 and divisor 2, which gives an 8 half-period output.
- R2: `cfg_word[14]` = 0 selects the crystal (`src_edge[0]`). `cfg_word[14]` = 1 selects a PLL: `cfg_word[13]` = 0 picks PLL1 (`src_edge[1]`) and 1 picks PLL2 (`src_edge[2]`). The counters advance only on strobes of the selected source.
- R3: The predivider code in `cfg_word[8:7]` takes the values 1, 2 and 3. One predivider step then lasts 4, 5 or 6 source half-periods, which is a ratio of 2, 2.5 or 3.
- R4: The divisor D is `cfg_word[6:0]`. An output period lasts P*D selected half-periods, where P is the step length from R3. `clk_out` is high for the first floor(D/2)*P of those half-periods and low for the rest.
- R5: A word with divisor 0 or 1, or with predivider code 0, is ignored. The previous active setting is kept.
- R6: An output period is never shorter than 8 source half-periods. The output frequency is therefore at most a quarter of the source.
- R7: `cfg_word[15]` is the enable. When it is low, `clk_out` is low from the next clock and the counters are cleared. After enable rises, a fresh period starts with the output high.
- R8: A legal word written while the block is enabled takes effect only at the end of the current output period. This covers the source, the predivider and the divisor, so no runt pulse appears.
- R9: Strobes on unselected sources have no effect on `clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 16 | Configuration: enable, source flags, predivider code, divisor |
| src_edge | input | 3 | One-cycle strobe per half-period of crystal, PLL1, PLL2 |
| clk_out | output | 1 | Divided output clock, registered |

## Verification
Two events can land on the same system-clock cycle. One is a configuration write. The other is the strobe that closes an output period, where the pending word is adopted and the counters wrap together. The bench rewrites the word while a long period is in progress and also across the closing strobe, with the crystal striking every cycle and PLL2 striking on a pseudo-random pattern. A behavioural phase-counter model decides on every clock whether the old or the new setting must govern the output.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
   localparam int CG_DIV_W   = 7;
   localparam int CG_PRE_W   = 2;
   localparam int CG_NSRC    = 3;
   localparam int CG_CFG_W   = 16;
   localparam int CG_EN_BIT  = 15;
   localparam int CG_PLL_BIT = 14;
   localparam int CG_P2_BIT  = 13;
   localparam int CG_PRE_LSB = 7;
   localparam int CG_DIV_LSB = 0;
   localparam int CG_MIN_DIV = 2;

   typedef struct packed {
      logic [1:0]          src_idx;
      logic [CG_PRE_W-1:0] pre_code;
      logic [CG_DIV_W-1:0] div;
   } cg_setting_t;

   localparam cg_setting_t CG_RESET_SET = '{src_idx: 2'd0, pre_code: 2'd1, div: 7'd2};
endpackage

// File: rtl/clkgen_cfg_hold.sv
module clkgen_cfg_hold
   import clkgen_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CG_CFG_W-1:0] cfg_word,
   input  logic                load,
   output cg_setting_t         act,
   output cg_setting_t         act_nxt
);
   cg_setting_t cand;
   logic        legal;

   always_comb begin
      cand.div      = cfg_word[CG_DIV_LSB +: CG_DIV_W];
      cand.pre_code = cfg_word[CG_PRE_LSB +: CG_PRE_W];
      if (!cfg_word[CG_PLL_BIT])     cand.src_idx = 2'd0;
      else if (!cfg_word[CG_P2_BIT]) cand.src_idx = 2'd1;
      else                           cand.src_idx = 2'd2;
      legal   = (cand.div >= CG_DIV_W'(CG_MIN_DIV)) && (cand.pre_code != '0);
      act_nxt = (load && legal) ? cand : act;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act <= CG_RESET_SET;
      else        act <= act_nxt;
   end
endmodule

// File: rtl/clkgen_src_pick.sv
module clkgen_src_pick #(
   parameter int NSRC = 3
) (
   input  logic [NSRC-1:0] src_edge,
   input  logic [1:0]      idx,
   output logic            tick
);
   logic [NSRC-1:0] hit;

   generate
      if (NSRC < 1 || NSRC > 4) begin : g_bad
         $error("clkgen_src_pick: NSRC must be 1..4");
      end
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         assign hit[s] = src_edge[s] && (idx == 2'(s));
      end
   endgenerate

   assign tick = |hit;
endmodule

// File: rtl/clkgen_chain.sv
module clkgen_chain #(
   parameter int DIV_W = 7,
   parameter int PRE_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [PRE_W-1:0] pre_code,
   input  logic [DIV_W-1:0] div,
   output logic [2:0]       pcnt,
   output logic [DIV_W-1:0] dcnt,
   output logic [DIV_W-1:0] dcnt_nxt,
   output logic             wrap
);
   localparam int PRE_OFS = 3;

   logic [2:0] plen_m1;
   logic [2:0] pcnt_nxt;
   logic       pre_end, div_end;

   generate
      if (DIV_W < 2) begin : g_bad
         $error("clkgen_chain: DIV_W must be at least 2");
      end
   endgenerate

   always_comb begin
      plen_m1 = 3'(pre_code) + 3'(PRE_OFS - 1);
      pre_end = (pcnt == plen_m1);
      div_end = (dcnt == div - DIV_W'(1));
      wrap    = step && pre_end && div_end;
      pcnt_nxt = pcnt;
      dcnt_nxt = dcnt;
      if (clear) begin
         pcnt_nxt = '0;
         dcnt_nxt = '0;
      end else if (step) begin
         if (pre_end) begin
            pcnt_nxt = '0;
            dcnt_nxt = div_end ? '0 : dcnt + DIV_W'(1);
         end else begin
            pcnt_nxt = pcnt + 3'd1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
         dcnt <= '0;
      end else begin
         pcnt <= pcnt_nxt;
         dcnt <= dcnt_nxt;
      end
   end
endmodule

// File: rtl/clk_frac_gen.sv
module clk_frac_gen
   import clkgen_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CG_CFG_W-1:0] cfg_word,
   input  logic [CG_NSRC-1:0]  src_edge,
   output logic                clk_out
);
   cg_setting_t         cur_set, nxt_set;
   logic                cfg_en, sel_tick, period_wrap;
   logic [2:0]          pcnt;
   logic [CG_DIV_W-1:0] dcnt, dcnt_nxt;
   logic [CG_DIV_W-1:0] act_div;
   logic [CG_PRE_W-1:0] act_pre;
   logic                out_d;

   assign cfg_en  = cfg_word[CG_EN_BIT];
   assign act_div = cur_set.div;
   assign act_pre = cur_set.pre_code;

   clkgen_cfg_hold u_hold (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
      .load(!cfg_en || period_wrap), .act(cur_set), .act_nxt(nxt_set)
   );

   clkgen_src_pick #(.NSRC(CG_NSRC)) u_pick (
      .src_edge(src_edge), .idx(cur_set.src_idx), .tick(sel_tick)
   );

   clkgen_chain #(.DIV_W(CG_DIV_W), .PRE_W(CG_PRE_W)) u_chain (
      .clk(clk), .rst_n(rst_n), .clear(!cfg_en), .step(cfg_en && sel_tick),
      .pre_code(cur_set.pre_code), .div(cur_set.div),
      .pcnt(pcnt), .dcnt(dcnt), .dcnt_nxt(dcnt_nxt), .wrap(period_wrap)
   );

   assign out_d = cfg_en && (dcnt_nxt < (nxt_set.div >> 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_out <= 1'b0;
      else        clk_out <= out_d;
   end
endmodule

// File: rtl/clk_frac_gen_chk.sv
module clk_frac_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic [2:0] src_edge,
   input logic       clk_out,
   input logic       wrap,
   input logic [6:0] act_div,
   input logic [1:0] act_pre,
   input logic [2:0] pcnt,
   input logic [6:0] dcnt
);
   p_low_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !clk_out);

   p_hold_without_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && src_edge == 3'b000) |=> $stable(clk_out));

   p_div_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_div >= 7'd2) && (act_pre != 2'd0));

   p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dcnt < act_div) && (pcnt <= 3'(act_pre) + 3'd2));

   p_cfg_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && ($changed(act_div) || $changed(act_pre))) |-> $past(wrap));
endmodule

bind clk_frac_gen clk_frac_gen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en(cfg_en), .src_edge(src_edge), .clk_out(clk_out),
   .wrap(period_wrap), .act_div(act_div), .act_pre(act_pre), .pcnt(pcnt), .dcnt(dcnt)
);

// File: tb/clk_frac_gen_bench.sv
module clk_frac_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_word = '0;
   logic [2:0]  src_edge = '0;
   logic        clk_out;

   int    total = 0, bad = 0, cyc = 0;
   string cur_req = "R1";
   bit    mute_pll1 = 0;
   logic [7:0] lfsr = 8'hA5;

   int m_div = 2, m_pre = 1, m_src = 0, m_phase = 0;
   bit exp_out = 0;

   always #4 clk = ~clk;

   clk_frac_gen u_clk_frac_gen (.clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
                                .src_edge(src_edge), .clk_out(clk_out));

   function automatic logic [15:0] mk(bit en, bit pll, bit p2, int pre, int dv);
      return {en, pll, p2, 4'b0, 2'(pre), 7'(dv)};
   endfunction

   // source strobe patterns: crystal every cycle, PLL1 every third, PLL2 pseudo-random
   always @(negedge clk) begin
      cyc++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      src_edge[0] = 1'b1;
      src_edge[1] = !mute_pll1 && (cyc % 3 == 0);
      src_edge[2] = lfsr[0];
   end

   // behavioural reference: phase counter over the whole output period
   always @(posedge clk) begin
      logic [15:0] w;
      bit legal;
      w = cfg_word;
      legal = (w[6:0] >= 2) && (w[8:7] != 0);
      if (!rst_n) begin
         m_div = 2; m_pre = 1; m_src = 0; m_phase = 0; exp_out = 0;
      end else if (!w[15]) begin
         if (legal) begin m_div = w[6:0]; m_pre = w[8:7]; m_src = w[14] ? (w[13] ? 2 : 1) : 0; end
         m_phase = 0; exp_out = 0;
      end else begin
         if (src_edge[m_src]) begin
            m_phase++;
            if (m_phase == (m_pre + 3) * m_div) begin
               m_phase = 0;
               if (legal) begin m_div = w[6:0]; m_pre = w[8:7]; m_src = w[14] ? (w[13] ? 2 : 1) : 0; end
            end
         end
         exp_out = m_phase < (m_div / 2) * (m_pre + 3);
      end
   end

   always @(negedge clk) begin
      total++;
      if (clk_out !== exp_out) begin
         bad++;
         $display("FAIL %s: clk_out=%0b expected=%0b at cycle %0d", cur_req, clk_out, exp_out, cyc);
      end
   end

   task automatic check(string req, int act, int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic run(string req, logic [15:0] w, int n);
      cur_req = req;
      cfg_word = w;
      repeat (n) @(negedge clk);
   endtask

   // period and high time measured in clocks between two rising edges (crystal strobes every cycle)
   task automatic measure(string req, int exp_per, int exp_hi);
      int per = 0, hi = 0, guard = 0;
      logic prev;
      cur_req = req;
      prev = clk_out;
      while (!( !prev && clk_out) && guard < 3000) begin prev = clk_out; @(negedge clk); guard++; end
      do begin
         if (clk_out) hi++;
         per++;
         prev = clk_out;
         @(negedge clk);
      end while (!(!prev && clk_out) && per < 3000);
      check(req, per, exp_per);
      check(req, hi, exp_hi);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", clk_out, 0);
      rst_n = 1'b1;
      // R1/R5: enabled with an illegal word keeps the reset setting (crystal, /2, D=2)
      run("R1", mk(1, 0, 0, 1, 0), 20);
      measure("R1", 8, 4);
      // R3/R4: 2.5 predivider with divisor 3 on the crystal
      run("R3", mk(0, 0, 0, 2, 3), 2);
      run("R3", mk(1, 0, 0, 2, 3), 40);
      measure("R4", 15, 5);
      run("R3", mk(1, 0, 0, 3, 5), 300);
      measure("R3", 30, 12);
      // R2: both PLL sources
      run("R2", mk(1, 1, 0, 3, 5), 600);
      run("R2", mk(1, 1, 1, 1, 4), 800);
      // R4: largest divisor, then R8: change applied only at the period end
      run("R4", mk(1, 0, 0, 1, 127), 700);
      run("R8", mk(1, 0, 0, 2, 2), 700);
      run("R8", mk(1, 1, 1, 2, 6), 37);
      run("R8", mk(1, 0, 0, 1, 9), 400);
      // R5: illegal divisor and illegal predivider code while enabled
      run("R5", mk(1, 0, 0, 1, 1), 200);
      measure("R5", 36, 16);
      run("R5", mk(1, 0, 0, 0, 5), 200);
      measure("R5", 36, 16);
      // R7: disable and re-enable
      run("R7", mk(0, 0, 0, 2, 7), 30);
      check("R7", clk_out, 0);
      run("R7", mk(1, 1, 1, 2, 7), 500);
      run("R7", mk(0, 1, 1, 2, 7), 1);
      check("R7", clk_out, 0);
      // R9: PLL1 selected and silent while other sources keep striking
      run("R9", mk(0, 1, 0, 1, 2), 3);
      mute_pll1 = 1;
      run("R9", mk(1, 1, 0, 1, 2), 3);
      check("R9", clk_out, 1);
      run("R9", mk(1, 1, 0, 1, 2), 200);
      check("R9", clk_out, 1);
      mute_pll1 = 0;
      run("R9", mk(1, 1, 0, 1, 2), 200);
      // R6: fastest legal setting on the crystal
      run("R6", mk(0, 0, 0, 1, 2), 3);
      run("R6", mk(1, 0, 0, 1, 2), 20);
      measure("R6", 8, 4);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule